// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the raster timing for one display pipe. Two counters run across each line and each frame. Count 0 on either axis is the leading edge of the sync pulse. Software programs the following through a small register port:

- the line length and the frame height, each written as the value minus one
- the sync widths
- the addressable sizes, front porches and borders

From these fields the block computes where blanking ends and where it starts. It then classifies every pixel as blank, border or active. Active pixels pass `pix_in` through to `pix_out`. Border pixels take a programmable overscan colour. Every other pixel takes a programmable black colour.

Timing fields are double-buffered, so a new mode takes effect cleanly at a frame boundary. A blank request is also deferred: it is applied where vertical blanking begins, and a read-only status bit reports when it is in force. The same point advances a frame counter.

A status word gives the live position and a vertical-blank flag. A fetch-request pulse tells the upstream pipeline when to start a frame. `cfg_ok` reports whether the pending horizontal timing meets the minimum blanking and porch rules.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, all of the following hold. Both counters are 0. The frame count is 0. The control read-back is 0. `hsync`, `vsync`, `de`, `border` and `fetch_req` are low. `pix_out` equals the black colour, which resets to 0. The status word reads 0x8000_0000.
- R2: While running, the horizontal count steps 0..HT and then returns to 0, where HT is the total field. The vertical count advances at each horizontal wrap and returns to 0 after VT. The status word (address 9) holds the horizontal count in bits [11:0], the vertical count in [23:12] and the vertical-blank flag in bit 31.
- R3: `hsync` is high exactly while the horizontal count is below the horizontal sync width. `vsync` is high exactly while the vertical count is below the vertical sync width.
- R4: On each axis, blank end E = (total+1) − (addressable + left + right + front porch). The left border covers [E, E+left). Active covers the next `addressable` counts. The right border follows, and blank starts at E + left + addressable + right.
- R5: `pix_out` depends on the region. In active video it is `pix_in`. Where either axis is in a border it is the overscan colour (address 8). Everywhere else it is the black colour (address 7). Colours pack component 0 in bits [9:0], component 1 in [19:10] and component 2 in [29:20].
- R6: Status bit 31 is 1 exactly when the vertical count lies outside [vertical E, vertical blank start).
- R7: The frame count (address 10) increments by one on each entry into vertical blank. The new value is visible from the second pixel of the first vertical-blank line.
- R8: Control bit 1 requests blanking. It is sampled only on entry into vertical blank, and read-back bit 3 then shows the applied state. While that state is 1, `de` and `border` stay low and `pix_out` is the black colour.
- R9: `fetch_req` pulses for one cycle at horizontal count 0 of the line that lies N lines before vertical E, wrapping modulo the frame height. N is 2 when control bit 2 (legacy) is set. Otherwise N is 3 if vertical sync width + vertical front porch ≤ 3, and 4 if not.
- R10: Timing writes (addresses 1–6) made while running take effect at the first pixel of the next frame. Writes made while stopped take effect at once.
- R11: Control bit 0 enables counting. When it is cleared, both counters settle to 0 and the sync and region outputs go low. When it is set again, counting resumes from (0,0).
- R12: `cfg_ok` is 1 only when the pending timing meets all four rules below:
  - horizontal blank (total − addressable − borders) is at least 56 clocks
  - horizontal front porch is at least 4
  - horizontal back porch (E − sync width) is at least 4
  - the vertical fields fit within the vertical total

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 control, 1–3 horizontal, 4–6 vertical, 7 black, 8 overscan) |
| wr_data | input | 32 | Write data; timing words hold {second field, first field} in 12-bit halves |
| rd_addr | input | 4 | Read address (adds 9 status, 10 frame count) |
| rd_data | output | 32 | Combinational read data |
| pix_in | input | 30 | Source pixel for active video |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-video enable |
| border | output | 1 | Border-region flag |
| fetch_req | output | 1 | One-cycle frame fetch request |
| cfg_ok | output | 1 | Pending timing meets the minimum rules |
| pix_out | output | 30 | Output pixel |

## Verification
The hardest situations to reach are the deferred ones:
- a blank request written in the middle of active video
- a new line length written while a frame is still in flight

Both have a visible effect only a frame boundary later. The bench keeps its own model of the raster position, advanced from the programmed totals and switched to the pending totals only at frame end. Each directed task walks the design to an exact (h, v) point: first to confirm that nothing has changed yet, then to the boundary where the change must appear. The fetch-lead rule is exercised by reprogramming the vertical fields while stopped, including a lead that wraps into the previous frame.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int CW         = 12,
  parameter int COLW       = 10,
  parameter int FCW        = 16,
  parameter int MIN_HBLANK = 56,
  parameter int MIN_HPORCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [3*COLW-1:0] pix_in,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              border,
  output logic              fetch_req,
  output logic              cfg_ok,
  output logic [3*COLW-1:0] pix_out
);
  localparam int PW = 3*COLW;
  localparam int SW = CW+3;
  localparam logic [CW-1:0]  ONE  = 1;
  localparam logic [FCW-1:0] FONE = 1;

  logic run, blank_req, legacy, blank_state, vblank_q;
  logic [CW-1:0] p_tot [2], p_sw [2], p_act [2], p_fp [2], p_lb [2], p_rb [2];
  logic [CW-1:0] a_tot [2], a_sw [2], a_act [2], a_fp [2], a_lb [2], a_rb [2];
  logic [CW-1:0] cnt [2];
  logic [PW-1:0] black_c, ovs_c;
  logic [FCW-1:0] frame_cnt;

  logic [CW-1:0] b_end [2], lb_end [2], act_end [2], b_start [2];
  logic in_win [2], in_act [2], in_sync [2], at_last [2];

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    assign b_end[ax]   = a_tot[ax] + ONE - (a_act[ax] + a_lb[ax] + a_rb[ax] + a_fp[ax]);
    assign lb_end[ax]  = b_end[ax] + a_lb[ax];
    assign act_end[ax] = lb_end[ax] + a_act[ax];
    assign b_start[ax] = act_end[ax] + a_rb[ax];
    assign in_win[ax]  = (cnt[ax] >= b_end[ax]) && (cnt[ax] < b_start[ax]);
    assign in_act[ax]  = (cnt[ax] >= lb_end[ax]) && (cnt[ax] < act_end[ax]);
    assign in_sync[ax] = cnt[ax] < a_sw[ax];
    assign at_last[ax] = cnt[ax] == a_tot[ax];
  end

  logic vblank_c, vb_rise, frame_end, commit, vis;
  assign vblank_c  = !run || !in_win[1];
  assign vb_rise   = run && vblank_c && !vblank_q;
  assign frame_end = run && at_last[0] && at_last[1];
  assign commit    = !run || frame_end;

  logic [CW-1:0] lead, fetch_line;
  assign lead = legacy ? CW'(2) :
                ((SW'(a_sw[1]) + SW'(a_fp[1]) <= SW'(3)) ? CW'(3) : CW'(4));
  assign fetch_line = (b_end[1] >= lead) ? b_end[1] - lead
                                         : b_end[1] + a_tot[1] + ONE - lead;

  logic [SW-1:0] h_len, h_vis, v_len, v_vis;
  assign h_len = SW'(p_tot[0]) + SW'(1);
  assign h_vis = SW'(p_act[0]) + SW'(p_lb[0]) + SW'(p_rb[0]);
  assign v_len = SW'(p_tot[1]) + SW'(1);
  assign v_vis = SW'(p_act[1]) + SW'(p_lb[1]) + SW'(p_rb[1]);
  assign cfg_ok = (h_len >= h_vis + SW'(MIN_HBLANK)) &&
                  (p_fp[0] >= CW'(MIN_HPORCH)) &&
                  (h_len >= h_vis + SW'(p_fp[0]) + SW'(p_sw[0]) + SW'(MIN_HPORCH)) &&
                  (v_len >= v_vis + SW'(p_fp[1]) + SW'(p_sw[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; blank_req <= 1'b0; legacy <= 1'b0;
      blank_state <= 1'b0; vblank_q <= 1'b1;
      black_c <= '0; ovs_c <= '0; frame_cnt <= '0;
      for (int i = 0; i < 2; i++) begin
        p_tot[i] <= '0; p_sw[i] <= '0; p_act[i] <= '0;
        p_fp[i] <= '0; p_lb[i] <= '0; p_rb[i] <= '0;
        a_tot[i] <= '0; a_sw[i] <= '0; a_act[i] <= '0;
        a_fp[i] <= '0; a_lb[i] <= '0; a_rb[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      vblank_q <= vblank_c;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin run <= wr_data[0]; blank_req <= wr_data[1]; legacy <= wr_data[2]; end
          4'd1: begin p_tot[0] <= wr_data[CW-1:0]; p_sw[0] <= wr_data[2*CW-1:CW]; end
          4'd2: begin p_act[0] <= wr_data[CW-1:0]; p_fp[0] <= wr_data[2*CW-1:CW]; end
          4'd3: begin p_lb[0]  <= wr_data[CW-1:0]; p_rb[0] <= wr_data[2*CW-1:CW]; end
          4'd4: begin p_tot[1] <= wr_data[CW-1:0]; p_sw[1] <= wr_data[2*CW-1:CW]; end
          4'd5: begin p_act[1] <= wr_data[CW-1:0]; p_fp[1] <= wr_data[2*CW-1:CW]; end
          4'd6: begin p_lb[1]  <= wr_data[CW-1:0]; p_rb[1] <= wr_data[2*CW-1:CW]; end
          4'd7: black_c <= wr_data[PW-1:0];
          4'd8: ovs_c   <= wr_data[PW-1:0];
          default: ;
        endcase
      end
      if (commit) begin
        for (int i = 0; i < 2; i++) begin
          a_tot[i] <= p_tot[i]; a_sw[i] <= p_sw[i]; a_act[i] <= p_act[i];
          a_fp[i]  <= p_fp[i];  a_lb[i] <= p_lb[i]; a_rb[i]  <= p_rb[i];
        end
      end
      if (!run) begin
        cnt[0] <= '0;
        cnt[1] <= '0;
      end else if (at_last[0]) begin
        cnt[0] <= '0;
        cnt[1] <= at_last[1] ? '0 : cnt[1] + ONE;
      end else begin
        cnt[0] <= cnt[0] + ONE;
      end
      if (vb_rise) begin
        blank_state <= blank_req;
        frame_cnt   <= frame_cnt + FONE;
      end
    end
  end

  assign hsync     = run && in_sync[0];
  assign vsync     = run && in_sync[1];
  assign vis       = run && in_win[0] && in_win[1] && !blank_state;
  assign de        = vis && in_act[0] && in_act[1];
  assign border    = vis && !(in_act[0] && in_act[1]);
  assign fetch_req = run && (cnt[0] == '0) && (cnt[1] == fetch_line);
  assign pix_out   = de ? pix_in : (border ? ovs_c : black_c);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      4'd0: rd_data[3:0] = {blank_state, legacy, blank_req, run};
      4'd1: rd_data[2*CW-1:0] = {p_sw[0], p_tot[0]};
      4'd2: rd_data[2*CW-1:0] = {p_fp[0], p_act[0]};
      4'd3: rd_data[2*CW-1:0] = {p_rb[0], p_lb[0]};
      4'd4: rd_data[2*CW-1:0] = {p_sw[1], p_tot[1]};
      4'd5: rd_data[2*CW-1:0] = {p_fp[1], p_act[1]};
      4'd6: rd_data[2*CW-1:0] = {p_rb[1], p_lb[1]};
      4'd7: rd_data[PW-1:0] = black_c;
      4'd8: rd_data[PW-1:0] = ovs_c;
      4'd9: begin
        rd_data[2*CW-1:0] = {cnt[1], cnt[0]};
        rd_data[31] = vblank_c;
      end
      4'd10: rd_data[FCW-1:0] = frame_cnt;
      default: ;
    endcase
  end

  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_last[0]) |=> (cnt[0] == '0));
  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt[0] < a_tot[0]) |=> (cnt[0] == $past(cnt[0]) + ONE));
  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt[0] == '0 && cnt[1] == '0));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!hsync && !vsync && !de && !border && !fetch_req));
  p_frame_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vb_rise |=> (frame_cnt == $past(frame_cnt) + FONE));
  p_blank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vb_rise |=> $stable(blank_state));
  p_fetch_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && a_tot[0] != '0) |=> !fetch_req);
endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [29:0] pix_in = {10'd777, 10'd555, 10'd333};
  logic        hsync, vsync, de, border, fetch_req, cfg_ok;
  logic [29:0] pix_out;

  localparam logic [29:0] BLK = {10'd3, 10'd2, 10'd1};
  localparam logic [29:0] OVS = {10'd300, 10'd200, 10'd100};

  int n_chk = 0, n_bad = 0;
  int bh = 0, bv = 0, bht = 1, bvt = 1, pht = 1, pvt = 1;
  bit brun = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_in(pix_in), .hsync(hsync), .vsync(vsync),
    .de(de), .border(border), .fetch_req(fetch_req), .cfg_ok(cfg_ok), .pix_out(pix_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at h=%0d v=%0d: actual=%h expected=%h", req, bh, bv, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) begin
      @(negedge clk);
      if (brun) begin
        if (bh == bht-1) begin
          bh = 0;
          if (bv == bvt-1) begin bv = 0; bht = pht; bvt = pvt; end
          else bv++;
        end else bh++;
      end else begin
        bh = 0; bv = 0; bht = pht; bvt = pvt;
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    adv(1);
    wr_en = 1'b0;
    if (a == 4'd0) brun = d[0];
    if (a == 4'd1) pht = int'(d[11:0]) + 1;
    if (a == 4'd4) pvt = int'(d[11:0]) + 1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic go(input int h, input int v);
    while (!(bh == h && bv == v)) adv(1);
  endtask

  function automatic logic [31:0] stat(input int h, input int v);
    logic vb = (v < 2) || (v >= 10);
    return {vb, 7'd0, 12'(v), 12'(h)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd9, d);  chk("R1 status", d, 32'h8000_0000);
    rd(4'd10, d); chk("R1 frame", d, 0);
    rd(4'd0, d);  chk("R1 ctrl", d, 0);
    chk("R1 outs", {27'd0, hsync, vsync, de, border, fetch_req}, 0);
    chk("R1 pix", 32'(pix_out), 0);
  endtask

  task automatic t_config();
    wr(4'd7, 32'(BLK));
    wr(4'd8, 32'(OVS));
    wr(4'd1, {8'd0, 12'd8, 12'd99});
    wr(4'd2, {8'd0, 12'd6, 12'd32});
    wr(4'd3, {8'd0, 12'd2, 12'd2});
    wr(4'd4, {8'd0, 12'd2, 12'd11});
    wr(4'd5, {8'd0, 12'd2, 12'd6});
    wr(4'd6, {8'd0, 12'd1, 12'd1});
    #1 chk("R12 valid timing", 32'(cfg_ok), 1);
    wr(4'd2, {8'd0, 12'd3, 12'd32});
    #1 chk("R12 short front porch", 32'(cfg_ok), 0);
    wr(4'd2, {8'd0, 12'd6, 12'd41});
    #1 chk("R12 short hblank", 32'(cfg_ok), 0);
    wr(4'd2, {8'd0, 12'd6, 12'd32});
    #1 chk("R12 restored", 32'(cfg_ok), 1);
  endtask

  task automatic t_count_sync();
    logic [31:0] d;
    wr(4'd0, 32'd1);
    rd(4'd9, d); chk("R11 start at origin", d, stat(0, 0));
    chk("R3 hsync at 0", 32'(hsync), 1);
    chk("R3 vsync at 0", 32'(vsync), 1);
    go(7, 0); chk("R3 hsync last", 32'(hsync), 1);
    adv(1);   chk("R3 hsync off", 32'(hsync), 0);
    go(99, 0); rd(4'd9, d); chk("R2 h at total", d, stat(99, 0));
    adv(1);    rd(4'd9, d); chk("R2 h wrap v step R6", d, stat(0, 1));
    chk("R3 vsync line1", 32'(vsync), 1);
    go(0, 2); chk("R3 vsync off", 32'(vsync), 0);
    rd(4'd9, d); chk("R6 vblank clear", d[31], 0);
  endtask

  task automatic t_regions();
    go(57, 5); chk("R4 blank before E", {de, border}, 0); chk("R5 black", pix_out, BLK);
    adv(1);    chk("R4 left border", {de, border}, 1);    chk("R5 overscan", pix_out, OVS);
    go(60, 5); chk("R4 active start", {de, border}, 2);   chk("R5 pass", pix_out, pix_in);
    go(91, 5); chk("R4 active end", {de, border}, 2);
    adv(1);    chk("R4 right border", {de, border}, 1);
    go(94, 5); chk("R4 blank start", {de, border}, 0);    chk("R5 black tail", pix_out, BLK);
    go(60, 9); chk("R4 bottom border", {de, border}, 1);
  endtask

  task automatic t_frame();
    logic [31:0] d;
    go(0, 10);
    rd(4'd10, d); chk("R7 frame before", d, 0);
    chk("R9 fetch lead 4", 32'(fetch_req), 1);
    chk("R4 vblank line", {de, border}, 0);
    adv(1);
    rd(4'd10, d); chk("R7 frame after", d, 1);
    chk("R9 fetch one cycle", 32'(fetch_req), 0);
    rd(4'd9, d); chk("R6 vblank set", d[31], 1);
  endtask

  task automatic t_blank();
    logic [31:0] d;
    go(60, 5);
    wr(4'd0, 32'd3);
    chk("R8 not yet blank", 32'(de), 1);
    rd(4'd0, d); chk("R8 state pending", d, 32'h3);
    go(0, 10); rd(4'd0, d); chk("R8 state at entry", d, 32'h3);
    adv(1);    rd(4'd0, d); chk("R8 state applied", d, 32'hB);
    go(60, 5); chk("R8 blanked region", {de, border}, 0);
    chk("R8 blanked pix", pix_out, BLK);
    go(58, 5); chk("R8 blanked border", 32'(border), 0);
    wr(4'd0, 32'd1);
    go(1, 10); rd(4'd0, d); chk("R8 unblanked", d, 32'h1);
    go(60, 5); chk("R8 video back", 32'(de), 1);
  endtask

  task automatic t_dbuf();
    logic [31:0] d;
    wr(4'd1, {8'd0, 12'd8, 12'd119});
    go(99, 6); adv(1);
    rd(4'd9, d); chk("R10 old total kept", d, stat(0, 7));
    go(119, 0); rd(4'd9, d); chk("R10 new total", d, stat(119, 0));
    adv(1);     rd(4'd9, d); chk("R10 new wrap", d, stat(0, 1));
  endtask

  task automatic t_stop_restart();
    logic [31:0] d;
    logic [31:0] f;
    rd(4'd10, f);
    wr(4'd0, 32'd0);
    adv(1);
    rd(4'd9, d);  chk("R11 stopped origin", d, 32'h8000_0000);
    chk("R11 idle outs", {27'd0, hsync, vsync, de, border, fetch_req}, 0);
    rd(4'd10, d); chk("R11 frame held", d, f);
    wr(4'd1, {8'd0, 12'd8, 12'd99});
    wr(4'd4, {8'd0, 12'd1, 12'd11});
    wr(4'd0, 32'd1);
    chk("R9 no fetch at 0 lead3", 32'(fetch_req), 0);
    go(0, 11); chk("R9 fetch lead 3 wrap", 32'(fetch_req), 1);
    go(99, 11); rd(4'd9, d); chk("R10 stopped write live", d, stat(99, 11));
    wr(4'd0, 32'd0);
    adv(1);
    wr(4'd0, 32'd5);
    rd(4'd9, d); chk("R11 restart origin", d, stat(0, 0));
    chk("R9 legacy lead 2", 32'(fetch_req), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_count_sync();
    t_regions();
    t_frame();
    t_blank();
    t_dbuf();
    t_stop_restart();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule